// File: doc/BRIEF.md
# Single-Cycle Hardware Loop Controller

This unit sits beside the decode stage of an in-order core and handles counted loops in hardware. A loop-arm instruction records two things: the address of the first instruction of the loop body, and a 32-bit mask. The mask marks the registers whose values are live after the loop ends. Each later loop-close instruction does three things in the same cycle. It adds a step to the index operand. It tests a condition. It either redirects fetch back to the recorded body start or lets the loop fall through. Because the target is recorded when the loop is armed, the close instruction needs no branch offset.

The close instruction has two forms.
- Form A compares the stepped index against a limit operand.
- Form B still steps the index, but continues only while a separate test operand is nonzero.

When the loop falls through, the unit emits a copy-out mask. The epilogue uses this mask to decide which loop registers are written back as scalar results; all other written registers are dropped. If an atomic instruction is decoded inside an armed loop, the loop falls back to scalar execution. In that case every register is kept at exit.

Top module: `hwloop_ctrl`

## Requirements
- R1: While reset is asserted and after its release, `active`, `scalar_mode`, `redir_vld`, `loop_exit`, `idx_wb_vld` and `copyout_vld` are 0, and the data outputs `redir_pc`, `idx_wb_data` and `copyout_mask` are 0.
- R2: A cycle with `setup_vld`=1 arms the loop from the next cycle. It records `setup_pc` as the redirect target and `setup_carry` as the copy-out mask.
- R3: Form A (`close_form`=0) continues when the stepped index `idx+step` satisfies `close_cond` against `close_opnd`, using two's-complement signed compares. The encodings are 00 less-than, 01 less-or-equal, 10 not-equal and 11 greater-or-equal. `idx_wb_data` carries `idx+step`, modulo 2^32.
- R4: Form B (`close_form`=1) continues exactly when `close_opnd` is nonzero, whatever the value of `close_cond`. The index is still stepped and written back.
- R5: An armed close that continues raises `redir_vld`, with `redir_pc` equal to the recorded target, and `idx_wb_vld` in the same cycle as `close_vld`.
- R6: An armed close that does not continue raises `loop_exit`, `copyout_vld` and `idx_wb_vld` in that cycle, and does not raise `redir_vld`. In that cycle `copyout_mask` equals the recorded mask. `active` is 0 from the next cycle unless a setup arrives in the same cycle.
- R7: A close while the unit is not armed produces no redirect, no write-back, no exit and no copy-out.
- R8: A setup while a loop is armed replaces the target and the mask. Later closes use the new values.
- R9: An atomic event while armed sets `scalar_mode` from the next cycle. `scalar_mode` holds until an exit or a setup. An exit taken while `scalar_mode`=1 drives `copyout_mask` to all ones.
- R10: An atomic event while the unit is not armed is ignored: `scalar_mode` stays 0, including after a later setup.
- R11: When setup and close arrive in the same cycle, the close is evaluated against the previously recorded loop, and the new loop is in force from the next cycle. A setup in that cycle also clears `scalar_mode`, even if `atom_vld` is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| setup_vld | input | 1 | Loop-arm instruction decoded |
| setup_pc | input | 32 | Address of the first body instruction |
| setup_carry | input | 32 | Mask of loop-carried registers, bit i for register i |
| close_vld | input | 1 | Loop-close instruction decoded |
| close_form | input | 1 | 0: compare with limit, 1: test operand against zero |
| close_cond | input | 2 | Form A condition code |
| close_idx | input | 32 | Current index register value |
| close_step | input | 32 | Step added to the index |
| close_opnd | input | 32 | Limit (form A) or tested register (form B) |
| atom_vld | input | 1 | Atomic instruction decoded |
| redir_vld | output | 1 | Branch back to loop body |
| redir_pc | output | 32 | Redirect target |
| loop_exit | output | 1 | Loop falls through this cycle |
| idx_wb_vld | output | 1 | Index write-back valid |
| idx_wb_data | output | 32 | Stepped index value |
| copyout_vld | output | 1 | Epilogue copy-out valid |
| copyout_mask | output | 32 | Registers to keep as scalar results |
| active | output | 1 | A loop is armed |
| scalar_mode | output | 1 | Armed loop must run as scalar code |

## Verification
The assertions check the following on every cycle:
- a redirect and an exit never occur together;
- a close while unarmed stays silent;
- every redirect arrives together with its index write-back, in the close cycle;
- form B follows the zero test;
- a setup arms the unit and fixes the next redirect target;
- an exit disarms the unit;
- `scalar_mode` never exists outside an armed loop.

Some behaviours need ordered scenarios from the bench instead:
- the exact form A condition outcomes with negative and wrapping values;
- a setup replacing a live loop;
- a setup and a close colliding in one cycle;
- an atomic event that is ignored before arming;
- the all-ones copy-out after a fallback.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;

  typedef enum logic [1:0] {
    CMP_LT = 2'b00,
    CMP_LE = 2'b01,
    CMP_NE = 2'b10,
    CMP_GE = 2'b11
  } cmp_e;

  typedef enum logic {
    FORM_LIMIT = 1'b0,
    FORM_NZ    = 1'b1
  } form_e;

endpackage

// File: rtl/hwloop_ctx.sv
module hwloop_ctx #(
  parameter int PC_W = 32,
  parameter int NREG = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            setup_vld,
  input  logic [PC_W-1:0] setup_pc,
  input  logic [NREG-1:0] setup_carry,
  input  logic            atom_vld,
  input  logic            exit_evt,
  output logic            active,
  output logic [PC_W-1:0] top_pc,
  output logic [NREG-1:0] carry_mask,
  output logic            scalar
);

  logic            active_q, active_d;
  logic            scalar_q, scalar_d;
  logic [PC_W-1:0] top_q;
  logic [NREG-1:0] mask_q;
  logic            load_en;

  // next-state
  always_comb begin
    load_en  = setup_vld;
    active_d = active_q;
    if (exit_evt)  active_d = 1'b0;
    if (setup_vld) active_d = 1'b1;
    scalar_d = scalar_q;
    if (active_q && atom_vld)  scalar_d = 1'b1;
    if (exit_evt || setup_vld) scalar_d = 1'b0;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      scalar_q <= 1'b0;
    end else begin
      active_q <= active_d;
      scalar_q <= scalar_d;
    end
  end

  // loop context, loaded only on setup
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q  <= '0;
      mask_q <= '0;
    end else if (load_en) begin
      top_q  <= setup_pc;
      mask_q <= setup_carry;
    end
  end

  assign active     = active_q;
  assign scalar     = scalar_q;
  assign top_pc     = top_q;
  assign carry_mask = mask_q;

endmodule

// File: rtl/hwloop_eval.sv
module hwloop_eval
  import hwloop_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter bit SIGNED_CMP = 1'b1
) (
  input  form_e             form,
  input  cmp_e              cond,
  input  logic [DATA_W-1:0] idx,
  input  logic [DATA_W-1:0] step,
  input  logic [DATA_W-1:0] opnd,
  output logic [DATA_W-1:0] idx_nxt,
  output logic              cont
);

  logic lt;
  logic eq;
  logic nz;

  assign idx_nxt = idx + step;
  assign eq      = (idx_nxt == opnd);
  assign nz      = |opnd;

  generate
    if (SIGNED_CMP) begin : g_signed
      assign lt = ($signed(idx_nxt) < $signed(opnd));
    end else begin : g_unsigned
      assign lt = (idx_nxt < opnd);
    end
  endgenerate

  always_comb begin
    if (form == FORM_NZ) begin
      cont = nz;
    end else begin
      case (cond)
        CMP_LT:  cont = lt;
        CMP_LE:  cont = lt | eq;
        CMP_NE:  cont = ~eq;
        default: cont = ~lt;
      endcase
    end
  end

endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
  import hwloop_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int DATA_W     = 32,
  parameter int NREG       = 32,
  parameter bit SIGNED_CMP = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              setup_vld,
  input  logic [PC_W-1:0]   setup_pc,
  input  logic [NREG-1:0]   setup_carry,
  input  logic              close_vld,
  input  logic              close_form,
  input  logic [1:0]        close_cond,
  input  logic [DATA_W-1:0] close_idx,
  input  logic [DATA_W-1:0] close_step,
  input  logic [DATA_W-1:0] close_opnd,
  input  logic              atom_vld,
  output logic              redir_vld,
  output logic [PC_W-1:0]   redir_pc,
  output logic              loop_exit,
  output logic              idx_wb_vld,
  output logic [DATA_W-1:0] idx_wb_data,
  output logic              copyout_vld,
  output logic [NREG-1:0]   copyout_mask,
  output logic              active,
  output logic              scalar_mode
);

  localparam logic [NREG-1:0] ALL_REGS = {NREG{1'b1}};

  logic              armed;
  logic              fallback;
  logic [PC_W-1:0]   top_pc;
  logic [NREG-1:0]   carry_mask;
  logic [DATA_W-1:0] idx_nxt;
  logic              cont;
  logic              live;
  logic              take;
  logic              leave;

  hwloop_eval #(
    .DATA_W     (DATA_W),
    .SIGNED_CMP (SIGNED_CMP)
  ) u_eval (
    .form    (form_e'(close_form)),
    .cond    (cmp_e'(close_cond)),
    .idx     (close_idx),
    .step    (close_step),
    .opnd    (close_opnd),
    .idx_nxt (idx_nxt),
    .cont    (cont)
  );

  assign live  = close_vld & armed;
  assign take  = live & cont;
  assign leave = live & ~cont;

  hwloop_ctx #(
    .PC_W (PC_W),
    .NREG (NREG)
  ) u_ctx (
    .clk         (clk),
    .rst_n       (rst_n),
    .setup_vld   (setup_vld),
    .setup_pc    (setup_pc),
    .setup_carry (setup_carry),
    .atom_vld    (atom_vld),
    .exit_evt    (leave),
    .active      (armed),
    .top_pc      (top_pc),
    .carry_mask  (carry_mask),
    .scalar      (fallback)
  );

  always_comb begin
    redir_vld    = take;
    redir_pc     = take ? top_pc : '0;
    loop_exit    = leave;
    idx_wb_vld   = live;
    idx_wb_data  = live ? idx_nxt : '0;
    copyout_vld  = leave;
    copyout_mask = '0;
    if (leave) copyout_mask = fallback ? ALL_REGS : carry_mask;
  end

  assign active      = armed;
  assign scalar_mode = fallback;

endmodule

// File: rtl/hwloop_ctrl_checker.sv
module hwloop_ctrl_checker #(
  parameter int PC_W   = 32,
  parameter int DATA_W = 32,
  parameter int NREG   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              setup_vld,
  input logic [PC_W-1:0]   setup_pc,
  input logic              close_vld,
  input logic              close_form,
  input logic [DATA_W-1:0] close_idx,
  input logic [DATA_W-1:0] close_step,
  input logic [DATA_W-1:0] close_opnd,
  input logic              atom_vld,
  input logic              redir_vld,
  input logic [PC_W-1:0]   redir_pc,
  input logic              loop_exit,
  input logic              idx_wb_vld,
  input logic [DATA_W-1:0] idx_wb_data,
  input logic              copyout_vld,
  input logic [NREG-1:0]   copyout_mask,
  input logic              active,
  input logic              scalar_mode
);

  assert_setup_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
    setup_vld |=> active);

  assert_target_recorded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    setup_vld |=> (!redir_vld || redir_pc == $past(setup_pc)));

  assert_wb_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wb_vld |-> idx_wb_data == close_idx + close_step);

  assert_nz_form_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (close_vld && active && close_form) |-> (redir_vld == (close_opnd != '0)));

  assert_same_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    redir_vld |-> (close_vld && idx_wb_vld));

  assert_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(redir_vld && loop_exit));

  assert_exit_disarms_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_exit && !setup_vld) |=> !active);

  assert_copy_with_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    copyout_vld |-> (loop_exit && idx_wb_vld));

  assert_idle_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (close_vld && !active) |-> (!redir_vld && !idx_wb_vld && !copyout_vld));

  assert_atomic_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (atom_vld && active && !loop_exit && !setup_vld) |=> scalar_mode);

  assert_scalar_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_exit && scalar_mode) |-> copyout_mask == {NREG{1'b1}});

  assert_no_idle_scalar_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !scalar_mode);

endmodule

bind hwloop_ctrl hwloop_ctrl_checker #(
  .PC_W   (PC_W),
  .DATA_W (DATA_W),
  .NREG   (NREG)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .setup_vld    (setup_vld),
  .setup_pc     (setup_pc),
  .close_vld    (close_vld),
  .close_form   (close_form),
  .close_idx    (close_idx),
  .close_step   (close_step),
  .close_opnd   (close_opnd),
  .atom_vld     (atom_vld),
  .redir_vld    (redir_vld),
  .redir_pc     (redir_pc),
  .loop_exit    (loop_exit),
  .idx_wb_vld   (idx_wb_vld),
  .idx_wb_data  (idx_wb_data),
  .copyout_vld  (copyout_vld),
  .copyout_mask (copyout_mask),
  .active       (active),
  .scalar_mode  (scalar_mode)
);

// File: tb/hwloop_ctrl_bench.sv
module hwloop_ctrl_bench;

  logic        clk;
  logic        rst_n;
  logic        setup_vld;
  logic [31:0] setup_pc;
  logic [31:0] setup_carry;
  logic        close_vld;
  logic        close_form;
  logic [1:0]  close_cond;
  logic [31:0] close_idx;
  logic [31:0] close_step;
  logic [31:0] close_opnd;
  logic        atom_vld;
  logic        redir_vld;
  logic [31:0] redir_pc;
  logic        loop_exit;
  logic        idx_wb_vld;
  logic [31:0] idx_wb_data;
  logic        copyout_vld;
  logic [31:0] copyout_mask;
  logic        active;
  logic        scalar_mode;

  int tests;
  int fails;

  // reference model state
  bit          m_active;
  bit          m_scalar;
  logic [31:0] m_top;
  logic [31:0] m_mask;

  hwloop_ctrl u_hwloop_ctrl (
    .clk(clk), .rst_n(rst_n),
    .setup_vld(setup_vld), .setup_pc(setup_pc), .setup_carry(setup_carry),
    .close_vld(close_vld), .close_form(close_form), .close_cond(close_cond),
    .close_idx(close_idx), .close_step(close_step), .close_opnd(close_opnd),
    .atom_vld(atom_vld),
    .redir_vld(redir_vld), .redir_pc(redir_pc), .loop_exit(loop_exit),
    .idx_wb_vld(idx_wb_vld), .idx_wb_data(idx_wb_data),
    .copyout_vld(copyout_vld), .copyout_mask(copyout_mask),
    .active(active), .scalar_mode(scalar_mode)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic bit model_cont();
    int signed a;
    int signed b;
    a = int'(close_idx + close_step);
    b = int'(close_opnd);
    if (close_form) return close_opnd != 0;
    case (close_cond)
      2'd0:    return a < b;
      2'd1:    return a <= b;
      2'd2:    return a != b;
      default: return a >= b;
    endcase
  endfunction

  task automatic idle_inputs();
    setup_vld   = 1'b0;
    setup_pc    = '0;
    setup_carry = '0;
    close_vld   = 1'b0;
    close_form  = 1'b0;
    close_cond  = 2'd0;
    close_idx   = '0;
    close_step  = '0;
    close_opnd  = '0;
    atom_vld    = 1'b0;
  endtask

  // one cycle: inputs already set after a negedge; compare, then advance model
  task automatic cyc(input string tag);
    bit          live, cont, go, out;
    logic [31:0] e_pc, e_wb, e_mask;
    logic [101:0] exp_v, act_v;
    #2;
    live   = close_vld && m_active && rst_n;
    cont   = model_cont();
    go     = live && cont;
    out    = live && !cont;
    e_pc   = go ? m_top : 32'h0;
    e_wb   = live ? close_idx + close_step : 32'h0;
    e_mask = out ? (m_scalar ? 32'hFFFF_FFFF : m_mask) : 32'h0;
    exp_v  = {go, e_pc, out, live, e_wb, out, e_mask, m_active, m_scalar};
    act_v  = {redir_vld, redir_pc, loop_exit, idx_wb_vld, idx_wb_data,
              copyout_vld, copyout_mask, active, scalar_mode};
    tests++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s: actual redir=%0b pc=%h exit=%0b wb=%0b/%h cp=%0b/%h act=%0b scl=%0b expected redir=%0b pc=%h exit=%0b wb=%0b/%h cp=%0b/%h act=%0b scl=%0b",
               tag, redir_vld, redir_pc, loop_exit, idx_wb_vld, idx_wb_data,
               copyout_vld, copyout_mask, active, scalar_mode,
               go, e_pc, out, live, e_wb, out, e_mask, m_active, m_scalar);
    end
    @(posedge clk);
    if (!rst_n) begin
      m_active = 0; m_scalar = 0; m_top = '0; m_mask = '0;
    end else begin
      if (m_active && atom_vld) m_scalar = 1;
      if (out || setup_vld)     m_scalar = 0;
      if (out)                  m_active = 0;
      if (setup_vld) begin
        m_active = 1; m_top = setup_pc; m_mask = setup_carry;
      end
    end
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_setup(input logic [31:0] pc, input logic [31:0] msk, input string tag);
    setup_vld = 1'b1; setup_pc = pc; setup_carry = msk;
    cyc(tag);
  endtask

  task automatic set_close(input bit form, input logic [1:0] cond,
                           input logic [31:0] idx, input logic [31:0] stp,
                           input logic [31:0] op);
    close_vld = 1'b1; close_form = form; close_cond = cond;
    close_idx = idx; close_step = stp; close_opnd = op;
  endtask

  task automatic do_close(input bit form, input logic [1:0] cond,
                          input logic [31:0] idx, input logic [31:0] stp,
                          input logic [31:0] op, input string tag);
    set_close(form, cond, idx, stp, op);
    cyc(tag);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL R1: watchdog expired, actual hung, expected completion");
    summary();
    $finish;
  end

  initial begin
    tests = 0; fails = 0;
    m_active = 0; m_scalar = 0; m_top = '0; m_mask = '0;
    idle_inputs();
    rst_n = 1'b0;
    @(negedge clk);
    // R1: quiet during reset, even with stimulus present
    cyc("R1");
    do_setup(32'h40, 32'h3, "R1");
    rst_n = 1'b1;
    cyc("R1");
    cyc("R1");

    // R7 close while idle; R10 atomic while idle
    do_close(1'b0, 2'd0, 32'd0, 32'd1, 32'd5, "R7");
    atom_vld = 1'b1; cyc("R10");
    do_setup(32'h100, 32'h0000_00F0, "R10");
    cyc("R10");

    // R3/R5/R6: less-than loop 0..3
    do_close(1'b0, 2'd0, 32'd0, 32'd1, 32'd3, "R5");
    do_close(1'b0, 2'd0, 32'd1, 32'd1, 32'd3, "R3");
    do_close(1'b0, 2'd0, 32'd2, 32'd1, 32'd3, "R6");
    cyc("R6");
    do_close(1'b0, 2'd0, 32'd0, 32'd1, 32'd3, "R7");

    // R3 conditions with signed and wrapping values
    do_setup(32'h180, 32'h1, "R2");
    do_close(1'b0, 2'd1, 32'd2, 32'd1, 32'd3, "R3");             // LE equal
    do_close(1'b0, 2'd2, 32'hFFFF_FFFE, 32'd1, 32'hFFFF_FFFF, "R3"); // NE equal -> exit
    do_setup(32'h1C0, 32'h2, "R2");
    do_close(1'b0, 2'd3, 32'd0, 32'hFFFF_FFFF, 32'hFFFF_FFF0, "R3"); // GE -1>=-16
    do_close(1'b0, 2'd0, 32'h7FFF_FFFF, 32'd1, 32'd5, "R3");        // wraps negative, LT
    do_close(1'b0, 2'd3, 32'd3, 32'd1, 32'd5, "R3");                // GE false -> exit

    // R4 nonzero form
    do_setup(32'h200, 32'h0000_0C00, "R4");
    do_close(1'b1, 2'd0, 32'd10, 32'd4, 32'd7, "R4");
    do_close(1'b1, 2'd3, 32'd14, 32'd4, 32'd0, "R4");

    // R8 replacement while armed
    do_setup(32'h300, 32'hAAAA_0000, "R8");
    do_setup(32'h340, 32'h0000_5555, "R8");
    do_close(1'b0, 2'd0, 32'd0, 32'd1, 32'd9, "R8");
    do_close(1'b0, 2'd0, 32'd9, 32'd1, 32'd9, "R8");

    // R9 atomic fallback
    do_setup(32'h400, 32'h0000_0001, "R9");
    atom_vld = 1'b1; cyc("R9");
    do_close(1'b1, 2'd0, 32'd0, 32'd1, 32'd1, "R9");
    do_close(1'b1, 2'd0, 32'd1, 32'd1, 32'd0, "R9");
    do_setup(32'h440, 32'h0000_0002, "R9");
    cyc("R9");

    // R11 setup colliding with close
    set_close(1'b0, 2'd0, 32'd0, 32'd1, 32'd5);
    setup_vld = 1'b1; setup_pc = 32'h500; setup_carry = 32'h8; atom_vld = 1'b1;
    cyc("R11");
    do_close(1'b0, 2'd0, 32'd1, 32'd1, 32'd5, "R11");
    set_close(1'b0, 2'd0, 32'd4, 32'd1, 32'd5);
    setup_vld = 1'b1; setup_pc = 32'h540; setup_carry = 32'h10;
    cyc("R11");
    do_close(1'b0, 2'd0, 32'd0, 32'd1, 32'd1, "R11");

    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom_range(0, 99);
      setup_vld   = (r < 10);
      setup_pc    = $urandom & 32'hFFFF_FFFC;
      setup_carry = $urandom;
      close_vld   = ($urandom_range(0, 1) == 1);
      close_form  = ($urandom_range(0, 3) == 0);
      close_cond  = 2'($urandom_range(0, 3));
      close_idx   = 32'($urandom_range(0, 20)) - 32'd10;
      close_step  = 32'($urandom_range(0, 4)) - 32'd2;
      close_opnd  = 32'($urandom_range(0, 20)) - 32'd10;
      atom_vld    = ($urandom_range(0, 9) == 0);
      cyc((setup_vld && close_vld) ? "R11" : "R3");
    end

    summary();
    $finish;
  end

endmodule